// File: doc/BRIEF.md
# Multi-Enable Interrupt Pending Aggregator

This block watches a fixed set of level-sensitive interrupt sources. Each source has a small enable counter. Enable strobes move the counter up or down. Each source also has a required enable total, fixed at instantiation. A source is pending only while its line is asserted and its counter sits exactly at that total. The block keeps a running count of pending sources and drives one CPU interrupt request, which is high whenever that count is nonzero.

For the CPU's current interrupt mask level, the block also presents the vector of the pending source with the lowest index. The vector is a 12-bit value taken from a per-source parameter table. A mask of 0xF blocks the vector. Decoding of software registers and priority arbitration between sources belong to the surrounding logic.

All ports are plain control or status pins. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure. Every input is sampled on every rising clock edge.

Top module: `irq_pend_agg`

## Requirements
- R1: A synchronous reset, active high, clears every asserted flag, every enable counter, every pending flag and the pending count. While reset is held, and after it is released with all inputs low, `cpu_irq` and `vec_valid` are 0 and `vec_out` is 0.
- R2: Source i is pending exactly when its asserted flag is 1 and its enable counter equals `REQ_TOTAL[i]`. A source whose required total is 0 is pending whenever it is asserted and its counter is 0.
- R3: A pulse on `en_inc[i]` alone adds one to counter i, and a pulse on `en_dec[i]` alone takes one away. Both pulses together, or neither, leave the counter unchanged. The counter saturates at 0 and at 2^CNT_W-1.
- R4: The pending count goes up by one for each source that turns pending and down by one for each that stops. `cpu_irq` is 1 exactly when that count is nonzero, so it stays high while any source is still pending.
- R5: The asserted flag of a source changes only when its level input differs from the flag. Holding the level high on an asserted source, or low on an idle source, has no effect.
- R6: When `cpu_mask` equals 4'hF, `vec_valid` is 0 and `vec_out` is 0, whatever is pending.
- R7: When `cpu_mask` is below 4'hF and at least one source is pending, `vec_valid` is 1 and `vec_out` equals `VECTORS[j]`, where j is the lowest index of any pending source.
- R8: When no source is pending, `vec_valid` is 0 and `vec_out` is 0.
- R9: A change on a level or enable input sampled at a rising edge is reflected in pending state, `cpu_irq` and the vector outputs right after that same edge, and not before it. `cpu_mask` acts combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_level | input | NUM_SRC | Level of each interrupt line |
| en_inc | input | NUM_SRC | One-cycle enable grant per source |
| en_dec | input | NUM_SRC | One-cycle enable withdrawal per source |
| cpu_mask | input | 4 | CPU interrupt mask level |
| cpu_irq | output | 1 | CPU interrupt request |
| vec_valid | output | 1 | A vector is being offered |
| vec_out | output | 12 | Vector of the selected pending source |

## Verification
The assertions check on every cycle that the incrementally kept pending count equals the population of pending flags, that `cpu_irq` agrees with the count, and that each pending flag agrees with its asserted flag and counter. They also check that an unchanged level leaves the asserted flag alone, that the counter does not wrap at either end, and that the mask blocks the vector. Only the bench scenarios can show the chosen vector against the lowest-index rule, the net effect of long enable sequences with saturation, and the one-edge latency seen at the ports.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int IRQ_VEC_W = 12;
  typedef logic [IRQ_VEC_W-1:0] irq_vec_t;
  localparam logic [3:0] MASK_ALL = 4'hF;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
  parameter int CNT_W = 3,
  parameter logic [CNT_W-1:0] REQ = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic inc,
  input  logic dec,
  output logic pend_d,
  output logic pend_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             asrt_q, asrt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else if (dec && !inc && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    asrt_d = asrt_q;
    if (level != asrt_q) asrt_d = level;
  end

  assign pend_d = asrt_d && (cnt_d == REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      asrt_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      asrt_q <= asrt_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  p_pend_rule_r2: assert property (@(posedge clk) disable iff (rst)
    pend_q == (asrt_q && (cnt_q == REQ)));
  p_cnt_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && dec && !inc) |=> (cnt_q == '0));
  p_cnt_ceil_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && inc && !dec) |=> (cnt_q == CNT_MAX));
  p_level_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (level == asrt_q) |=> $stable(asrt_q));
endmodule

// File: rtl/irq_pend_counter.sv
module irq_pend_counter #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_d,
  input  logic [NUM_SRC-1:0] pend_q,
  output logic               cpu_irq
);
  localparam int PC_W = $clog2(NUM_SRC + 1);

  logic [PC_W-1:0] pc_q, pc_d, rises, falls;

  always_comb begin
    rises = '0;
    falls = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_d[i] && !pend_q[i]) rises = rises + 1'b1;
      if (!pend_d[i] && pend_q[i]) falls = falls + 1'b1;
    end
    pc_d = pc_q + rises - falls;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      cpu_irq <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      cpu_irq <= (pc_d != '0);
    end
  end

  p_count_matches_r4: assert property (@(posedge clk) disable iff (rst)
    pc_q == PC_W'($countones(pend_q)));
  p_irq_follows_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (pc_q != '0));
endmodule

// File: rtl/irq_vec_select.sv
module irq_vec_select
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter irq_vec_t [NUM_SRC-1:0] VECTORS = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [3:0]         cpu_mask,
  output logic               vec_valid,
  output irq_vec_t           vec_out
);
  logic     found;
  irq_vec_t pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && !found) begin
        found = 1'b1;
        pick  = VECTORS[i];
      end
    end
  end

  assign vec_valid = found && (cpu_mask != MASK_ALL);
  assign vec_out   = vec_valid ? pick : '0;

  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_mask == MASK_ALL) |-> (!vec_valid && vec_out == '0));
  p_idle_novec_r8: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |-> !vec_valid);
endmodule

// File: rtl/irq_pend_agg.sv
module irq_pend_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CNT_W = 3,
  parameter logic [NUM_SRC-1:0][CNT_W-1:0] REQ_TOTAL =
    {3'd1, 3'd2, 3'd1, 3'd0, 3'd3, 3'd1, 3'd2, 3'd1},
  parameter irq_vec_t [NUM_SRC-1:0] VECTORS =
    {12'h5E0, 12'h5C0, 12'h5A0, 12'h580, 12'h560, 12'h540, 12'h520, 12'h500}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [NUM_SRC-1:0] en_inc,
  input  logic [NUM_SRC-1:0] en_dec,
  input  logic [3:0]         cpu_mask,
  output logic               cpu_irq,
  output logic               vec_valid,
  output logic [11:0]        vec_out
);
  logic [NUM_SRC-1:0] pend_d, pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    irq_src_slot #(.CNT_W(CNT_W), .REQ(REQ_TOTAL[g])) u_slot (
      .clk(clk), .rst(rst), .level(src_level[g]),
      .inc(en_inc[g]), .dec(en_dec[g]),
      .pend_d(pend_d[g]), .pend_q(pend_q[g])
    );
  end

  irq_pend_counter #(.NUM_SRC(NUM_SRC)) u_cnt (
    .clk(clk), .rst(rst), .pend_d(pend_d), .pend_q(pend_q), .cpu_irq(cpu_irq)
  );

  irq_vec_select #(.NUM_SRC(NUM_SRC), .VECTORS(VECTORS)) u_sel (
    .clk(clk), .rst(rst), .pend(pend_q), .cpu_mask(cpu_mask),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!cpu_irq && !vec_valid));
endmodule

// File: tb/irq_pend_agg_tb.sv
module irq_pend_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 3;
  localparam logic [N-1:0][W-1:0] REQ =
    {3'd1, 3'd2, 3'd1, 3'd0, 3'd3, 3'd1, 3'd2, 3'd1};
  localparam logic [N-1:0][11:0] VEC =
    {12'h5E0, 12'h5C0, 12'h5A0, 12'h580, 12'h560, 12'h540, 12'h520, 12'h500};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_level = '0, en_inc = '0, en_dec = '0;
  logic [3:0] cpu_mask = 4'h0;
  logic cpu_irq, vec_valid;
  logic [11:0] vec_out;

  int checks = 0;
  int errors = 0;
  int m_cnt [N];
  logic [N-1:0] m_asrt;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_agg #(.NUM_SRC(N), .CNT_W(W), .REQ_TOTAL(REQ), .VECTORS(VEC)) u_dut (
    .clk(clk), .rst(rst), .src_level(src_level), .en_inc(en_inc),
    .en_dec(en_dec), .cpu_mask(cpu_mask), .cpu_irq(cpu_irq),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  function automatic logic [N-1:0] exp_pend();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) p[i] = m_asrt[i] && (m_cnt[i] == int'(REQ[i]));
    return p;
  endfunction

  function automatic logic [11:0] exp_vec(input logic [N-1:0] p, input logic [3:0] m);
    if (m == 4'hF) return 12'h0;
    for (int i = 0; i < N; i++) if (p[i]) return VEC[i];
    return 12'h0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    for (int i = 0; i < N; i++) begin
      m_asrt[i] = src_level[i];
      if (en_inc[i] && !en_dec[i] && m_cnt[i] < (1 << W) - 1) m_cnt[i]++;
      else if (en_dec[i] && !en_inc[i] && m_cnt[i] > 0) m_cnt[i]--;
    end
  endtask

  task automatic check_all(input string ctx);
    logic [N-1:0] p;
    p = exp_pend();
    chk({"R4 R2 cpu_irq ", ctx}, int'(cpu_irq), int'(p != '0));
    chk({"R6 R7 R8 vec_valid ", ctx}, int'(vec_valid),
        int'((p != '0) && cpu_mask != 4'hF));
    chk({"R7 vec_out ", ctx}, int'(vec_out), int'(exp_vec(p, cpu_mask)));
  endtask

  task automatic step(input string ctx);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(ctx);
    en_inc = '0;
    en_dec = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_asrt = '0;
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 cpu_irq in reset", int'(cpu_irq), 0);
    chk("R1 vec_valid in reset", int'(vec_valid), 0);
    rst = 1'b0;
    step("R1 after reset");

    // R9: source 4 needs zero grants; pending appears only after the edge
    src_level[4] = 1'b1;
    #1;
    chk("R9 cpu_irq before edge", int'(cpu_irq), 0);
    step("R9 after edge");
    chk("R9 vec source4", int'(vec_out), int'(VEC[4]));
    // R5: holding the level high changes nothing
    step("R5 hold high");
    chk("R5 still pending", int'(cpu_irq), 1);
    // R6: full mask blocks the vector
    cpu_mask = 4'hF;
    #1;
    chk("R6 blocked valid", int'(vec_valid), 0);
    chk("R6 blocked vec", int'(vec_out), 0);
    cpu_mask = 4'h3;
    // R3: one grant to source 4 takes it out of pending
    en_inc[4] = 1'b1;
    step("R3 grant on zero-req");
    chk("R3 zero-req lost pending", int'(cpu_irq), 0);
    // R3: saturation high: ten grants then four withdrawals on all
    src_level = '1;
    for (int k = 0; k < 10; k++) begin en_inc = '1; step("R3 inc"); end
    for (int k = 0; k < 4; k++) begin en_dec = '1; step("R3 dec"); end
    chk("R3 ceil gives source3", int'(vec_out), int'(VEC[3]));
    // R3: saturation low then one grant
    for (int k = 0; k < 10; k++) begin en_dec = '1; step("R3 dec floor"); end
    en_inc = '1;
    en_dec = 8'h0F;
    step("R3 both strobes");
    en_inc = '1;
    step("R3 inc from floor");
    chk("R3 floor gives source0", int'(vec_out), int'(VEC[0]));
    // R4: dropping lowest pending keeps irq while others remain
    src_level[0] = 1'b0;
    step("R4 drop source0");
    chk("R4 irq held", int'(cpu_irq), 1);
    chk("R7 next lowest", int'(vec_out), int'(VEC[2]));
    src_level = '0;
    step("R4 all idle");
    chk("R8 idle vec", int'(vec_out), 0);

    for (int k = 0; k < 4000; k++) begin
      src_level = N'($urandom);
      en_inc = N'($urandom & $urandom);
      en_dec = N'($urandom & $urandom);
      cpu_mask = ($urandom % 5 == 0) ? 4'hF : 4'($urandom % 15);
      step("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule